// File: doc/BRIEF.md
# Two-Wire Register-File Slave with Counter Snapshot

This block is the serial front end of a clock and calendar chip. It lets a two-wire (I2C) bus master read and write a 256-byte space. The bytes at locations 01 to 07 hold the running counters, and location 00 is the control register. The rest is plain storage.

A transfer names the device and picks the direction. In a write, the first data byte sets the word pointer. Each later byte is stored at the pointer, and the pointer then moves up by one. A read returns bytes from the pointer onward, and the pointer moves up by one after each byte.

When a read begins, all seven counter bytes are frozen into a bank of snapshot latches. Every counter byte read in that transfer comes from the snapshot, so a carry that ripples through the counters cannot tear the value the master sees. The counter logic outside this block updates the counter locations through a narrow side port.

A mask bit in the control register hides the packed year and weekday fields. The master then reads the date and month counts directly.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the slave does not pull SDA low, and every location, including control register 00, reads as 00.
- R2: The slave acknowledges an address byte only if its upper seven bits equal binary 101000 followed by the level of `addrPin`. Bit 0 selects read (1) or write (0). With `addrPin` low the write address is A0 and the read address is A1. With `addrPin` high they are A2 and A3. The slave ignores the rest of a transfer that carries any other address byte.
- R3: In a write transfer, the first data byte loads the word pointer. Each later byte is stored at the pointer, and the pointer then increments.
- R4: A read returns the byte at the pointer and then increments the pointer. The pointer wraps from FF to 00.
- R5: Control register 00 reads back the value last written to it over the bus.
- R6: A read transfer samples locations 01 to 07 into latches once, when its address byte is accepted. Counter bytes read in that transfer come from those latches, even if the counters change during the transfer. The next read transfer sees the new values.
- R7: A bus write to one counter location leaves the other counter locations unchanged.
- R8: When bit 3 of register 00 is set, reads of location 05 return bits 7:6 as zero and reads of location 06 return bits 7:5 as zero. Other locations are not affected. When bit 3 is clear, all bits are returned.
- R9: The slave pulls SDA low on the ninth clock of every data byte it receives. In a read, it stops driving SDA once the master answers a byte with a not-acknowledge.
- R10: A STOP or a repeated START aborts the byte in progress. A STOP in the middle of a byte writes nothing. After a repeated START, a new address byte is decoded from its first bit.
- R11: A side-port update with `ctrSel` equal to k (1 to 7) writes location k. `ctrSel` = 0 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are oversampled on it |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired-AND of all drivers) |
| addrPin | input | 1 | Strap that selects the device address bit 1 |
| sdaDrvLow | output | 1 | 1 = pull the data line low, 0 = release it |
| ctrWrEn | input | 1 | Counter logic update strobe |
| ctrSel | input | 3 | Counter location to update (1 to 7) |
| ctrData | input | 8 | New counter byte |

## Verification
The assertions assume that SCL stays high and stays low each for several system clocks longer than the two-stage synchroniser. They also assume that the master changes SDA while SCL is high only to make a START or a STOP, and never starts a condition while the slave holds the line low. Under those assumptions the slave's own drive may change only while SCL is low. The stimulus runs every bus phase for four system clocks. It changes SDA only in the low phase of SCL, and it issues STOP or repeated START only after the slave has released the line, so each transfer stays inside what the checks assume.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  // Strobes from the bus controller to the storage datapath
  typedef struct packed {
    logic ptrLoad;   // load word pointer from received byte
    logic ptrInc;    // advance word pointer
    logic memWrite;  // store received byte at pointer
    logic snapTake;  // freeze counter bytes into latches
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } busState_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WORD,
    PH_DATA
  } rxPhase_t;

endpackage

// File: rtl/i2c_reg_sync.sv
module i2c_reg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  logic [STAGES-1:0] sclChain;
  logic [STAGES-1:0] sdaChain;
  logic sclP;
  logic sdaP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclP     <= 1'b1;
      sdaP     <= 1'b1;
    end else begin
      sclChain <= {sclChain[STAGES-2:0], sclIn};
      sdaChain <= {sdaChain[STAGES-2:0], sdaIn};
      sclP     <= sclS;
      sdaP     <= sdaS;
    end
  end

  assign sclS    = sclChain[STAGES-1];
  assign sdaS    = sdaChain[STAGES-1];
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startEv = sclS & sclP & sdaP & ~sdaS;
  assign stopEv  = sclS & sclP & ~sdaP & sdaS;

endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter int         DW        = 8,
  parameter logic [5:0] DEV_ID_HI = 6'h28
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sdaS,
  input  logic          sclRise,
  input  logic          sclFall,
  input  logic          startEv,
  input  logic          stopEv,
  input  logic          addrPin,
  input  logic [DW-1:0] txByte,
  output dpCtl_t        ctl,
  output logic [DW-1:0] rxByte,
  output logic          sdaDrvLow
);

  localparam int BW = $clog2(DW + 1);
  localparam logic [BW-1:0] FULL = BW'(DW);
  localparam logic [BW-1:0] LAST = BW'(DW - 1);

  busState_t     state;
  rxPhase_t      phase;
  logic [DW-1:0] shiftReg;
  logic [BW-1:0] bitCnt;
  logic          isRead;
  logic          mAck;
  logic          drive;
  logic          byteDone;
  logic          devHit;
  logic          loadTx;

  assign rxByte    = shiftReg;
  assign sdaDrvLow = drive;
  assign devHit    = (shiftReg[DW-1:1] == {DEV_ID_HI, addrPin});
  assign byteDone  = (state == ST_RX) && sclFall && (bitCnt == FULL)
                     && !startEv && !stopEv;
  assign loadTx    = sclFall && !startEv && !stopEv &&
                     (((state == ST_RXACK) && isRead) ||
                      ((state == ST_TXACK) && mAck));

  always_comb begin
    ctl = '0;
    if (byteDone) begin
      unique case (phase)
        PH_DEV:  ctl.snapTake = devHit & shiftReg[0];
        PH_WORD: ctl.ptrLoad  = 1'b1;
        default: begin
          ctl.memWrite = 1'b1;
          ctl.ptrInc   = 1'b1;
        end
      endcase
    end
    if (loadTx) ctl.ptrInc = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_DEV;
      shiftReg <= '0;
      bitCnt   <= '0;
      isRead   <= 1'b0;
      mAck     <= 1'b0;
      drive    <= 1'b0;
    end else if (stopEv) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      drive  <= 1'b0;
    end else if (startEv) begin
      state  <= ST_RX;
      phase  <= PH_DEV;
      bitCnt <= '0;
      isRead <= 1'b0;
      drive  <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise && bitCnt != FULL) begin
            shiftReg <= {shiftReg[DW-2:0], sdaS};
            bitCnt   <= bitCnt + 1'b1;
          end else if (byteDone) begin
            if (phase == PH_DEV && !devHit) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_RXACK;
              drive <= 1'b1;
              if (phase == PH_DEV) begin
                isRead <= shiftReg[0];
                phase  <= shiftReg[0] ? PH_DATA : PH_WORD;
              end else begin
                phase <= PH_DATA;
              end
            end
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              state    <= ST_TX;
              shiftReg <= txByte;
              drive    <= ~txByte[DW-1];
            end else begin
              state <= ST_RX;
              drive <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == LAST) begin
              state  <= ST_TXACK;
              drive  <= 1'b0;
              bitCnt <= '0;
            end else begin
              shiftReg <= {shiftReg[DW-2:0], 1'b0};
              drive    <= ~shiftReg[DW-2];
              bitCnt   <= bitCnt + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            mAck <= ~sdaS;
          end else if (sclFall) begin
            if (mAck) begin
              state    <= ST_TX;
              shiftReg <= txByte;
              drive    <= ~txByte[DW-1];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_reg_dp.sv
module i2c_reg_dp
  import i2c_reg_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int CTR_FIRST = 1,
  parameter int CTR_COUNT = 7,
  parameter int MASK_BIT  = 3,
  parameter int DATE_LOC  = 5,
  parameter int MONTH_LOC = 6,
  parameter int YEAR_W    = 2,
  parameter int WDAY_W    = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [DW-1:0]           rxByte,
  input  logic                    ctrWrEn,
  input  logic [$clog2(CTR_COUNT+1)-1:0] ctrSel,
  input  logic [DW-1:0]           ctrData,
  output logic [DW-1:0]           txByte,
  output logic [AW-1:0]           ptr,
  output logic [DW-1:0]           ctrlReg,
  output logic [CTR_COUNT*DW-1:0] snapFlat
);

  localparam int DEPTH = 2 ** AW;
  localparam int CSW   = $clog2(CTR_COUNT + 1);
  localparam int SIW   = (CTR_COUNT > 1) ? $clog2(CTR_COUNT) : 1;
  localparam logic [AW-1:0] CTR_LO  = AW'(CTR_FIRST);
  localparam logic [AW-1:0] CTR_HI  = AW'(CTR_FIRST + CTR_COUNT - 1);
  localparam logic [AW-1:0] DATE_A  = AW'(DATE_LOC);
  localparam logic [AW-1:0] MONTH_A = AW'(MONTH_LOC);

  logic [DW-1:0] mem   [DEPTH];
  logic [DW-1:0] snapQ [CTR_COUNT];
  logic [AW-1:0] ctrLoc;
  logic          ctrValid;
  logic          inWin;
  logic [SIW-1:0] snapSel;

  assign ctrLoc   = CTR_LO - AW'(1) + AW'(ctrSel);
  assign ctrValid = ctrWrEn && (ctrSel != '0) && (ctrSel <= CSW'(CTR_COUNT));
  assign ctrlReg  = mem[0];

  // Pointer and storage; a bus write wins over a same-cycle counter update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (ctl.ptrLoad)     ptr <= rxByte[AW-1:0];
      else if (ctl.ptrInc) ptr <= ptr + 1'b1;
      if (ctrValid)        mem[ctrLoc] <= ctrData;
      if (ctl.memWrite)    mem[ptr] <= rxByte;
    end
  end

  // One snapshot latch per counter location
  for (genvar gi = 0; gi < CTR_COUNT; gi++) begin : gSnap
    always_ff @(posedge clk) begin
      if (!rstN)             snapQ[gi] <= '0;
      else if (ctl.snapTake) snapQ[gi] <= mem[CTR_FIRST + gi];
    end
    assign snapFlat[gi*DW +: DW] = snapQ[gi];
  end

  assign inWin   = (ptr >= CTR_LO) && (ptr <= CTR_HI);
  assign snapSel = SIW'(ptr - CTR_LO);

  always_comb begin
    txByte = inWin ? snapQ[snapSel] : mem[ptr];
    if (ctrlReg[MASK_BIT]) begin
      if (ptr == DATE_A)  txByte[DW-1 -: YEAR_W] = '0;
      if (ptr == MONTH_A) txByte[DW-1 -: WDAY_W] = '0;
    end
  end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter int         AW          = 8,
  parameter int         DW          = 8,
  parameter int         CTR_FIRST   = 1,
  parameter int         CTR_COUNT   = 7,
  parameter int         MASK_BIT    = 3,
  parameter int         DATE_LOC    = 5,
  parameter int         MONTH_LOC   = 6,
  parameter int         YEAR_W      = 2,
  parameter int         WDAY_W      = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ID_HI   = 6'h28
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           sclIn,
  input  logic                           sdaIn,
  input  logic                           addrPin,
  output logic                           sdaDrvLow,
  input  logic                           ctrWrEn,
  input  logic [$clog2(CTR_COUNT+1)-1:0] ctrSel,
  input  logic [DW-1:0]                  ctrData
);

  logic sclS, sdaS, sclRise, sclFall, startEv, stopEv;
  dpCtl_t ctl;
  logic [DW-1:0] rxByte;
  logic [DW-1:0] txByte;
  logic [AW-1:0] ptr;
  logic [DW-1:0] ctrlReg;
  logic [CTR_COUNT*DW-1:0] snapFlat;

  i2c_reg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  i2c_reg_ctrl #(.DW(DW), .DEV_ID_HI(DEV_ID_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclRise(sclRise),
    .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .addrPin(addrPin), .txByte(txByte), .ctl(ctl), .rxByte(rxByte),
    .sdaDrvLow(sdaDrvLow)
  );

  i2c_reg_dp #(
    .AW(AW), .DW(DW), .CTR_FIRST(CTR_FIRST), .CTR_COUNT(CTR_COUNT),
    .MASK_BIT(MASK_BIT), .DATE_LOC(DATE_LOC), .MONTH_LOC(MONTH_LOC),
    .YEAR_W(YEAR_W), .WDAY_W(WDAY_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxByte(rxByte),
    .ctrWrEn(ctrWrEn), .ctrSel(ctrSel), .ctrData(ctrData),
    .txByte(txByte), .ptr(ptr), .ctrlReg(ctrlReg), .snapFlat(snapFlat)
  );

endmodule

// File: rtl/i2c_reg_chk.sv
module i2c_reg_chk
  import i2c_reg_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int SNAPW = 56
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclS,
  input logic             startEv,
  input logic             stopEv,
  input logic             sdaDrvLow,
  input dpCtl_t           ctl,
  input logic [AW-1:0]    ptr,
  input logic [DW-1:0]    ctrlReg,
  input logic [SNAPW-1:0] snapFlat
);

  // R9
  sda_quiet_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS) && !$past(startEv) && !$past(stopEv))
      |-> $stable(sdaDrvLow));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ptrInc && !ctl.ptrLoad) |=> (ptr == AW'($past(ptr) + 1'b1)));

  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.memWrite |=> $stable(ctrlReg));

  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.snapTake |=> $stable(snapFlat));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaDrvLow);

  // R10
  stop_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |-> !ctl.memWrite);

endmodule

bind i2c_reg_slave i2c_reg_chk #(.AW(AW), .DW(DW), .SNAPW(CTR_COUNT*DW)) u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .startEv(startEv), .stopEv(stopEv),
  .sdaDrvLow(sdaDrvLow), .ctl(ctl), .ptr(ptr), .ctrlReg(ctrlReg),
  .snapFlat(snapFlat)
);

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;

  localparam int Q = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       addrPin = 1'b1;
  logic       ctrWrEn = 1'b0;
  logic [2:0] ctrSel = '0;
  logic [7:0] ctrData = '0;
  logic       sdaDrvLow;
  logic       sdaLine;
  logic [7:0] rdBuf [8];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  assign sdaLine = sdaM & ~sdaDrvLow;

  i2c_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .addrPin(addrPin), .sdaDrvLow(sdaDrvLow), .ctrWrEn(ctrWrEn),
    .ctrSel(ctrSel), .ctrData(ctrData)
  );

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] devW();
    return {6'h28, addrPin, 1'b0};
  endfunction

  function automatic logic [7:0] devR();
    return {6'h28, addrPin, 1'b1};
  endfunction

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    ack = ~sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic readByte(input logic doAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      sclM = 1'b1; waitQ();
      b[i] = sdaLine; waitQ();
      sclM = 1'b0; waitQ();
    end
    sendBit(~doAck);
  endtask

  task automatic writeReg(input logic [7:0] addr, input logic [7:0] d, input string req);
    logic ack;
    busStart();
    writeByte(devW(), ack);  check("R2", {7'b0, ack}, 8'h01);
    writeByte(addr, ack);    check("R9", {7'b0, ack}, 8'h01);
    writeByte(d, ack);       check(req,  {7'b0, ack}, 8'h01);
    busStop();
  endtask

  task automatic readFrom(input logic [7:0] addr, input int n);
    logic ack;
    busStart();
    writeByte(devW(), ack);  check("R2", {7'b0, ack}, 8'h01);
    writeByte(addr, ack);    check("R9", {7'b0, ack}, 8'h01);
    busStart();
    writeByte(devR(), ack);  check("R2", {7'b0, ack}, 8'h01);
    for (int i = 0; i < n; i++) readByte(i != n - 1, rdBuf[i]);
    check("R9 release after NACK", {7'b0, sdaDrvLow}, 8'h00);
    busStop();
  endtask

  task automatic ctrPoke(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    ctrWrEn = 1'b1; ctrSel = sel; ctrData = d;
    @(negedge clk);
    ctrWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] dummy;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: released line and cleared storage after reset
    check("R1 drive", {7'b0, sdaDrvLow}, 8'h00);
    readFrom(8'h00, 2);
    check("R1 loc00", rdBuf[0], 8'h00);
    check("R1 loc01", rdBuf[1], 8'h00);

    // R2: sweep every address byte with both strap levels
    for (int p = 0; p < 2; p++) begin
      addrPin = p[0];
      for (int a = 0; a < 256; a++) begin
        logic [7:0] ab;
        logic       expAck;
        ab = 8'(a);
        expAck = (ab[7:1] == {6'h28, p[0]});
        busStart();
        writeByte(ab, ack);
        check("R2 address match", {7'b0, ack}, {7'b0, expAck});
        if (ack && ab[0]) readByte(1'b0, dummy);
        busStop();
      end
    end
    addrPin = 1'b1;

    // R3: pointer load then sequential writes
    busStart();
    writeByte(devW(), ack);  check("R2", {7'b0, ack}, 8'h01);
    writeByte(8'h20, ack);   check("R9", {7'b0, ack}, 8'h01);
    writeByte(8'h11, ack);   check("R9", {7'b0, ack}, 8'h01);
    writeByte(8'h22, ack);   check("R9", {7'b0, ack}, 8'h01);
    writeByte(8'h33, ack);   check("R9", {7'b0, ack}, 8'h01);
    busStop();
    readFrom(8'h20, 3);
    check("R3 seq0", rdBuf[0], 8'h11);
    check("R3 seq1", rdBuf[1], 8'h22);
    check("R3 seq2", rdBuf[2], 8'h33);
    writeReg(8'h21, 8'h44, "R3");
    readFrom(8'h20, 3);
    check("R3 single0", rdBuf[0], 8'h11);
    check("R3 single1", rdBuf[1], 8'h44);
    check("R3 single2", rdBuf[2], 8'h33);

    // R4: wrap FF -> 00 on write and on read
    busStart();
    writeByte(devW(), ack);
    writeByte(8'hFE, ack);
    writeByte(8'h5E, ack);
    writeByte(8'h7F, ack);
    writeByte(8'h04, ack);
    busStop();
    readFrom(8'hFE, 4);
    check("R4 FE", rdBuf[0], 8'h5E);
    check("R4 FF", rdBuf[1], 8'h7F);
    check("R4 wrap00", rdBuf[2], 8'h04);
    check("R4 wrap01", rdBuf[3], 8'h00);

    // R5: control register round trip
    writeReg(8'h00, 8'hA4, "R5");
    readFrom(8'h00, 1);
    check("R5 ctrl", rdBuf[0], 8'hA4);

    // R11: side port fills counters; selector 0 touches nothing
    for (int k = 1; k <= 7; k++) ctrPoke(3'(k), 8'hC0 + 8'(k));
    ctrPoke(3'd0, 8'hFF);
    readFrom(8'h00, 8);
    check("R11 sel0 ignored", rdBuf[0], 8'hA4);
    for (int k = 1; k <= 7; k++) check("R11 counter", rdBuf[k], 8'hC0 + 8'(k));

    // R7: bus write to one counter leaves the others
    writeReg(8'h03, 8'h5A, "R7");
    readFrom(8'h01, 7);
    for (int k = 1; k <= 7; k++)
      check("R7 counters", rdBuf[k-1], (k == 3) ? 8'h5A : 8'hC0 + 8'(k));

    // R6: snapshot holds during a read, refreshes on the next one
    busStart();
    writeByte(devW(), ack);
    writeByte(8'h01, ack);
    busStart();
    writeByte(devR(), ack);  check("R2", {7'b0, ack}, 8'h01);
    readByte(1'b1, rdBuf[0]);
    ctrPoke(3'd1, 8'h77);
    ctrPoke(3'd2, 8'h99);
    readByte(1'b0, rdBuf[1]);
    busStop();
    check("R6 frozen1", rdBuf[0], 8'hC1);
    check("R6 frozen2", rdBuf[1], 8'hC2);
    readFrom(8'h01, 2);
    check("R6 fresh1", rdBuf[0], 8'h77);
    check("R6 fresh2", rdBuf[1], 8'h99);

    // R8: mask of packed fields
    writeReg(8'h00, 8'h08, "R8");
    readFrom(8'h04, 3);
    check("R8 loc04 unmasked", rdBuf[0], 8'hC4);
    check("R8 loc05 masked", rdBuf[1], 8'h05);
    check("R8 loc06 masked", rdBuf[2], 8'h06);
    writeReg(8'h00, 8'h00, "R8");
    readFrom(8'h05, 2);
    check("R8 loc05 full", rdBuf[0], 8'hC5);
    check("R8 loc06 full", rdBuf[1], 8'hC6);

    // R10: STOP mid-byte writes nothing
    busStart();
    writeByte(devW(), ack);
    writeByte(8'h40, ack);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStop();
    readFrom(8'h40, 1);
    check("R10 stop mid-byte", rdBuf[0], 8'h00);

    // R10: repeated START mid-address restarts decoding
    writeReg(8'h50, 8'h3C, "R10");
    busStart();
    writeByte(devW(), ack);
    writeByte(8'h50, ack);
    busStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b0); sendBit(1'b1);
    busStart();
    writeByte(devR(), ack);  check("R10 ack after restart", {7'b0, ack}, 8'h01);
    readByte(1'b0, rdBuf[0]);
    check("R9 release after NACK", {7'b0, sdaDrvLow}, 8'h00);
    busStop();
    check("R10 read after restart", rdBuf[0], 8'h3C);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule